// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Status Flags

This block receives 8-bit frames from a serial data line in clocked (synchronous) mode. A serial clock comes with the data. It is already synchronous to the system clock. Each rising edge of the serial clock samples one data bit, and bits arrive least significant first. When the eighth bit, the most significant one, arrives, the completed byte moves into a holding data register and a data-ready flag sets.

Four flags describe the receiver's condition: data-ready, overrun, parity error and framing error. The parity and framing flags are set by pulse inputs. In this mode nothing inside the block detects those conditions. While any of the three error flags is set, reception halts until software clears the flag.

Software clears a flag with a two-step handshake: it reads the status, then writes 0 to the flag. A DMA engine that answers the receive interrupt can read the data register with an acknowledge strobe, and that strobe clears data-ready by itself.

Top module: `srx_top`

## Requirements
- R1: After synchronous reset, all four flags, the interrupt output and the data register are 0.
- R2: While `rx_en` is 1 and no error flag is set, each rising edge of `ser_clk` shifts in `ser_data`, least significant bit first. The edge is seen at the first system clock edge where `ser_clk` is 1 after being 0. At the eighth bit, `rx_data` takes the byte and `st_ready` sets on that same clock edge.
- R3: `rx_irq` is high for exactly the cycles in which `st_ready` has just changed from 0 to 1.
- R4: If `st_ready` is 1 when the eighth bit of a frame arrives, `st_overrun` sets. In that case `rx_data` keeps the earlier byte, the new frame is discarded and `st_ready` stays 1.
- R5: A flag clears only when `st_wr` writes 0 to its bit after an `st_rd` strobe that saw that flag as 1. Writing 1 has no effect. A write with no such earlier read has no effect. The write bit map is bit 0 data-ready, bit 1 overrun, bit 2 parity, bit 3 framing.
- R6: If a flag's set condition and its clear happen in the same cycle, the flag stays set.
- R7: `dma_ack` clears `st_ready` on the next clock edge unless a new byte is stored in that same cycle.
- R8: While overrun, parity or framing is set, serial clock edges are ignored, the bit count holds and `st_ready` cannot set. Reception resumes once every error flag has been cleared.
- R9: While `rx_en` is 0, the bit count is held at zero and serial clock edges are ignored, so a partly received frame is dropped.
- R10: A pulse on `set_par_err` sets `st_parity`, and a pulse on `set_frm_err` sets `st_framing`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| ser_clk | input | 1 | Serial clock, already synchronous to clk |
| ser_data | input | 1 | Serial data |
| set_par_err | input | 1 | Parity error set pulse |
| set_frm_err | input | 1 | Framing error set pulse |
| st_rd | input | 1 | Status read strobe, arms the clear of flags seen as 1 |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 4 | Status write data; a 0 clears an armed flag |
| dma_ack | input | 1 | DMA data read; clears data-ready |
| rx_data | output | 8 | Received data register |
| st_ready | output | 1 | Data-ready flag |
| st_overrun | output | 1 | Overrun flag |
| st_parity | output | 1 | Parity error flag |
| st_framing | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive-full interrupt pulse |

## Verification
A wrong bit count shows up at the ports within one frame. The byte arrives early or late, `st_ready` rises at the wrong serial edge, or the bits come out rotated in `rx_data`. A lockout that fails to hold lets a frame complete while an error flag is set, which changes `rx_data` or `st_ready` on the eighth edge. A wrong armed-clear state shows in the cycle after a status write, when a flag drops that should hold or holds when it should drop. The reference model compares every output on every clock, so any of these is reported in the cycle where it first appears.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int FRAME_W = 8;
    localparam int FLAG_N  = 4;

    localparam int F_READY = 0;
    localparam int F_OVR   = 1;
    localparam int F_PAR   = 2;
    localparam int F_FRM   = 3;

    typedef logic [FLAG_N-1:0] flag_vec_t;

    function automatic logic err_any(flag_vec_t f);
        return f[F_OVR] | f[F_PAR] | f[F_FRM];
    endfunction
endpackage

// File: rtl/srx_edge.sv
module srx_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R2: a detected edge never repeats on the next cycle
    a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int W = srx_pkg::FRAME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         halt,
    input  logic         rise,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] frame
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt;
    logic [W-2:0]     sh;
    logic             take;

    assign take  = en & ~halt & rise;
    assign done  = take & (cnt == LAST);
    assign frame = {din, sh};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (take) begin
            sh  <= {din, sh[W-2:1]};
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

    // R9: disabled receiver keeps its count at zero
    a_r9_cnt_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0);
    // R8: a halted receiver does not advance its count
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        halt |=> (cnt == $past(cnt)) || (cnt == '0));
endmodule

// File: rtl/srx_status.sv
module srx_status
    import srx_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         done,
    input  logic [W-1:0] frame,
    input  logic         par_set,
    input  logic         frm_set,
    input  logic         rd,
    input  logic         wr,
    input  flag_vec_t    wdata,
    input  logic         dma,
    output flag_vec_t    flags,
    output logic [W-1:0] data,
    output logic         irq
);
    flag_vec_t armed, set_v, clr_v;
    logic store;

    assign store          = done & ~flags[F_READY];
    assign set_v[F_READY] = store;
    assign set_v[F_OVR]   = done & flags[F_READY];
    assign set_v[F_PAR]   = par_set;
    assign set_v[F_FRM]   = frm_set;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        logic sw_clr;
        assign sw_clr = wr & armed[i] & ~wdata[i];
        if (i == F_READY) begin : g_dma
            assign clr_v[i] = sw_clr | dma;
        end else begin : g_sw
            assign clr_v[i] = sw_clr;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                armed[i] <= 1'b0;
            end else begin
                flags[i] <= set_v[i] | (flags[i] & ~clr_v[i]);
                if (wr)      armed[i] <= 1'b0;
                else if (rd) armed[i] <= flags[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= store;
            if (store) data <= frame;
        end
    end

    // R3: interrupt only with a fresh rise of the ready flag
    a_r3_irq_rise: assert property (@(posedge clk) disable iff (rst)
        irq |-> flags[F_READY] && !$past(flags[F_READY]));
    // R4: overrun leaves the held byte untouched
    a_r4_keep_data: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_OVR]) |-> $stable(data));
    // R7: DMA read drops ready unless a byte is stored at once
    a_r7_dma_clear: assert property (@(posedge clk) disable iff (rst)
        (dma && !done) |=> !flags[F_READY]);
    // R8: ready cannot rise while parity or framing is flagged
    a_r8_no_ready: assert property (@(posedge clk) disable iff (rst)
        (flags[F_PAR] || flags[F_FRM]) |=> !$rose(flags[F_READY]));
endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_en,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               set_par_err,
    input  logic               set_frm_err,
    input  logic               st_rd,
    input  logic               st_wr,
    input  logic [FLAG_N-1:0]  st_wdata,
    input  logic               dma_ack,
    output logic [FRAME_W-1:0] rx_data,
    output logic               st_ready,
    output logic               st_overrun,
    output logic               st_parity,
    output logic               st_framing,
    output logic               rx_irq
);
    logic               rise, done;
    logic [FRAME_W-1:0] frame;
    flag_vec_t          flags;

    srx_edge i_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ser_clk),
        .rise (rise)
    );

    srx_shift #(.W(FRAME_W)) i_shift (
        .clk   (clk),
        .rst   (rst),
        .en    (rx_en),
        .halt  (err_any(flags)),
        .rise  (rise),
        .din   (ser_data),
        .done  (done),
        .frame (frame)
    );

    srx_status #(.W(FRAME_W)) i_status (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .frame   (frame),
        .par_set (set_par_err),
        .frm_set (set_frm_err),
        .rd      (st_rd),
        .wr      (st_wr),
        .wdata   (st_wdata),
        .dma     (dma_ack),
        .flags   (flags),
        .data    (rx_data),
        .irq     (rx_irq)
    );

    assign st_ready   = flags[F_READY];
    assign st_overrun = flags[F_OVR];
    assign st_parity  = flags[F_PAR];
    assign st_framing = flags[F_FRM];
endmodule

// File: tb/test_srx_top.sv
module test_srx_top;
    logic clk = 0, rst = 1;
    logic rx_en = 0, ser_clk = 0, ser_data = 0, set_par_err = 0, set_frm_err = 0;
    logic st_rd = 0, st_wr = 0, dma_ack = 0;
    logic [3:0] st_wdata = 4'hF;
    logic [7:0] rx_data;
    logic st_ready, st_overrun, st_parity, st_framing, rx_irq;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    srx_top i_srx_top (.*);

    // behavioural reference
    int m_prev = 1, m_cnt = 0, m_sh = 0, m_data = 0, m_irq = 0;
    bit m_fl[4];
    bit m_arm[4];

    always @(posedge clk) begin
        if (rst) begin
            m_prev = 1; m_cnt = 0; m_sh = 0; m_data = 0; m_irq = 0;
            foreach (m_fl[i]) begin m_fl[i] = 0; m_arm[i] = 0; end
        end else begin
            bit rs, dn, blocked;
            bit nf[4];
            int fr;
            rs = ser_clk && (m_prev == 0);
            m_prev = ser_clk;
            blocked = m_fl[1] | m_fl[2] | m_fl[3];
            dn = 0; fr = 0;
            if (!rx_en) m_cnt = 0;
            else if (!blocked && rs) begin
                fr = (int'(ser_data) << 7) | m_sh;
                m_sh = (m_sh >> 1) | (int'(ser_data) << 6);
                if (m_cnt == 7) begin dn = 1; m_cnt = 0; end
                else m_cnt++;
            end
            for (int i = 0; i < 4; i++) begin
                bit clr;
                clr = st_wr && m_arm[i] && !st_wdata[i];
                if (i == 0 && dma_ack) clr = 1;
                nf[i] = m_fl[i] && !clr;
            end
            m_irq = 0;
            if (dn && !m_fl[0]) begin nf[0] = 1; m_data = fr; m_irq = 1; end
            if (dn && m_fl[0]) nf[1] = 1;
            if (set_par_err) nf[2] = 1;
            if (set_frm_err) nf[3] = 1;
            for (int i = 0; i < 4; i++) begin
                if (st_wr) m_arm[i] = 0;
                else if (st_rd) m_arm[i] = m_fl[i];
                m_fl[i] = nf[i];
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (!rst) begin
        chk(cur_req, "rx_data", rx_data, m_data);
        chk(cur_req, "st_ready", st_ready, m_fl[0]);
        chk(cur_req, "st_overrun", st_overrun, m_fl[1]);
        chk(cur_req, "st_parity", st_parity, m_fl[2]);
        chk(cur_req, "st_framing", st_framing, m_fl[3]);
        chk(cur_req, "rx_irq", rx_irq, m_irq);
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            ser_data = b[i]; ser_clk = 0; tick();
            ser_clk = 1; tick();
        end
        ser_clk = 0; tick();
    endtask

    task automatic sw_clear(logic [3:0] w);
        st_rd = 1; tick(); st_rd = 0;
        st_wr = 1; st_wdata = w; tick(); st_wr = 0; st_wdata = 4'hF; tick();
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(); tick(); rst = 0; tick();
        chk("R1", "reset flags", {st_framing, st_parity, st_overrun, st_ready, rx_irq}, 0);
        chk("R1", "reset data", rx_data, 0);

        cur_req = "R9"; send_bits(8'hFF, 4);          // ignored, disabled
        chk("R9", "ready while off", st_ready, 0);
        rx_en = 1; tick();

        cur_req = "R2"; send_bits(8'hA5, 8);
        chk("R2", "byte", rx_data, 8'hA5);
        chk("R3", "ready", st_ready, 1);

        cur_req = "R7"; dma_ack = 1; tick(); dma_ack = 0; tick();
        chk("R7", "dma clear", st_ready, 0);

        cur_req = "R3"; send_bits(8'h3C, 8);
        cur_req = "R4"; send_bits(8'h77, 8);
        chk("R4", "kept byte", rx_data, 8'h3C);
        chk("R4", "overrun", st_overrun, 1);

        cur_req = "R8"; send_bits(8'h11, 8);
        chk("R8", "locked byte", rx_data, 8'h3C);

        cur_req = "R5"; st_wr = 1; st_wdata = 4'h0; tick(); st_wr = 0; st_wdata = 4'hF; tick();
        chk("R5", "no-read write", st_overrun, 1);
        sw_clear(4'b1101);
        chk("R5", "overrun cleared", st_overrun, 0);
        chk("R5", "ready kept", st_ready, 1);
        sw_clear(4'b1110);
        chk("R5", "ready cleared", st_ready, 0);

        cur_req = "R10"; set_par_err = 1; tick(); set_par_err = 0; tick();
        chk("R10", "parity", st_parity, 1);
        cur_req = "R6"; st_rd = 1; tick(); st_rd = 0;
        st_wr = 1; st_wdata = 4'h0; set_par_err = 1; tick();
        st_wr = 0; st_wdata = 4'hF; set_par_err = 0; tick();
        chk("R6", "set wins", st_parity, 1);
        cur_req = "R8"; send_bits(8'h5A, 8);
        chk("R8", "no ready under parity", st_ready, 0);
        sw_clear(4'b1011);
        cur_req = "R10"; set_frm_err = 1; tick(); set_frm_err = 0; tick();
        chk("R10", "framing", st_framing, 1);
        sw_clear(4'b0111);
        chk("R8", "framing cleared", st_framing, 0);

        cur_req = "R9"; send_bits(8'h0F, 4);
        rx_en = 0; tick(); rx_en = 1; tick();
        cur_req = "R2"; send_bits(8'hC3, 8);
        chk("R9", "fresh frame", rx_data, 8'hC3);
        chk("R2", "ready after resume", st_ready, 1);
        tick(); tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule